// File: doc/BRIEF.md
# Downstream Slot Fundamental Reset Sequencer

This block drives the active-low fundamental reset line of a downstream PCIe slot. It watches three inputs: a power-good level, a reference-clock-stable level and a sleep request. The reset stays asserted until the supply has been good for 100 ms and the reference clock has been stable for a lead time chosen at run time. Only when both conditions are met does the block release reset. After release it keeps configuration traffic toward the device blocked for another 100 ms. It also watches a link-detect input. If the device does not reach link detect within its deadline, the block raises a flag. The deadline is 20 ms for links capped at 5.0 GT/s and 100 ms for faster links.

Every interval is counted in ticks of a 1 ms prescaler, which is derived from the clock-frequency parameter. Each interval is rounded up, so no minimum is ever cut short. A sleep request asserts reset first and grants permission to remove power one tick later. A loss of power-good with no warning asserts reset at once, restarts every timer and drops the configuration enable. The asynchronous inputs pass through two-flop synchronizers.

Top module: `perst_seq`

## Requirements
- R1: After power-good rises, `perst_n_o` stays low for at least 100 ms (100 × CLK_HZ/1000 clock cycles).
- R2: Release also waits until `refclk_ok_i` has been high for at least `clk_lead_ms_i` ms. `perst_n_o` rises no later than 2 ms plus 10 cycles after the later of the two conditions is met.
- R3: `cfg_enable_o` is low whenever `perst_n_o` is low. It rises no earlier than 100 ms and no later than 102 ms plus 10 cycles after `perst_n_o` rises.
- R4: When `sleep_req_i` is high while reset is released, `perst_n_o` and `cfg_enable_o` are low at the next clock edge. `power_off_ok_o` then rises at least 1 ms and at most 3 ms plus 10 cycles later, and it is only ever high while `perst_n_o` is low.
- R5: When `pwr_good_i` falls, `perst_n_o` and `cfg_enable_o` are low within 4 cycles and `power_off_ok_o` stays low. A new rise of power-good restarts the full 100 ms interval.
- R6: `detect_timeout_o` rises if `link_detect_i` has not risen by the deadline after release. The deadline is 20 ms when `fast_link_i` = 0 and 100 ms when `fast_link_i` = 1. The flag stays low if detect arrives well before the deadline.
- R7: `detect_timeout_o` is sticky while reset is released, and it is cleared by the next assertion of `perst_n_o`.
- R8: While `rst` is high, and in the cycle after it, `perst_n_o` = 0 and `cfg_enable_o`, `power_off_ok_o` and `detect_timeout_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_i | input | 1 | Slot supply within tolerance (asynchronous) |
| refclk_ok_i | input | 1 | Reference clock stable (asynchronous) |
| link_detect_i | input | 1 | Downstream link reached Detect (asynchronous) |
| fast_link_i | input | 1 | 1: link above 5.0 GT/s (100 ms deadline); 0: 20 ms deadline |
| clk_lead_ms_i | input | 8 | Required clock-stable lead before release, in ms |
| sleep_req_i | input | 1 | Planned power-down request (synchronous level) |
| perst_n_o | output | 1 | Active-low fundamental reset to the slot |
| cfg_enable_o | output | 1 | Configuration traffic permitted |
| power_off_ok_o | output | 1 | Supply may be switched off |
| detect_timeout_o | output | 1 | Sticky link-detect deadline miss |

## Verification
The assertions assume the following:
- `sleep_req_i` is synchronous to `clk`.
- `fast_link_i` and `clk_lead_ms_i` are static while reset is released.
- Power-good and clock-stable change slowly compared with the two-flop synchronizers.

The stimulus drives every input on the falling edge. It sets the configuration inputs only while power-good is low, and it holds each asynchronous level for many milliseconds. The deadline vectors place detect arrival far from the 20 ms and 100 ms boundaries, so tick rounding cannot make an expected result ambiguous.

// File: rtl/perst_seq_pkg.sv
package perst_seq_pkg;
  typedef enum logic [2:0] {
    RESET_HOLD = 3'd0,
    WAIT_POWER = 3'd1,
    WAIT_CLK   = 3'd2,
    RELEASED   = 3'd3,
    CFG_WINDOW = 3'd4,
    ACTIVE     = 3'd5,
    PRE_OFF    = 3'd6
  } seq_state_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/psq_sync.sv
module psq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/psq_tick.sv
module psq_tick #(
  parameter int DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/psq_timer.sv
module psq_timer #(
  parameter int CAP = 255,
  localparam int W  = $clog2(CAP + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CAP_V = W'(CAP);

  always_ff @(posedge clk) begin
    if (rst || clr)                 count <= '0;
    else if (tick && count != CAP_V) count <= count + 1'b1;
  end

  p_saturate_r1: assert property (@(posedge clk) disable iff (rst)
    count <= CAP_V);
endmodule

// File: rtl/perst_seq.sv
module perst_seq
  import perst_seq_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int PWR_MS      = 100,
  parameter int CFG_MS      = 100,
  parameter int DET_SLOW_MS = 20,
  parameter int DET_FAST_MS = 100,
  parameter int OFF_MS      = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good_i,
  input  logic       refclk_ok_i,
  input  logic       link_detect_i,
  input  logic       fast_link_i,
  input  logic [7:0] clk_lead_ms_i,
  input  logic       sleep_req_i,
  output logic       perst_n_o,
  output logic       cfg_enable_o,
  output logic       power_off_ok_o,
  output logic       detect_timeout_o
);
  localparam int TICK_DIV = (CLK_HZ + 999) / 1000;
  localparam int POST_CAP = max2(CFG_MS, DET_FAST_MS) + 1;
  localparam int PW = $clog2(PWR_MS + 2);
  localparam int LW = $clog2(257);
  localparam int QW = $clog2(POST_CAP + 1);
  localparam int OW = $clog2(OFF_MS + 2);

  logic       tick;
  logic [2:0] sync_q;
  logic       pg_s, clk_s, det_s;
  logic [PW-1:0] pwr_cnt;
  logic [LW-1:0] lead_cnt;
  logic [QW-1:0] post_cnt;
  logic [OW-1:0] off_cnt;
  logic pwr_done, clk_done, cfg_done, off_done, det_late;
  logic det_seen;
  seq_state_t st, nxt;
  logic nxt_rel;

  psq_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst),
    .d({link_detect_i, refclk_ok_i, pwr_good_i}), .q(sync_q));
  assign {det_s, clk_s, pg_s} = sync_q;

  psq_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  // Every "done" needs limit+1 tick edges so the interval is never short.
  psq_timer #(.CAP(PWR_MS + 1)) u_pwr (
    .clk(clk), .rst(rst), .clr(!pg_s), .tick(tick), .count(pwr_cnt));
  psq_timer #(.CAP(256)) u_lead (
    .clk(clk), .rst(rst), .clr(!clk_s), .tick(tick), .count(lead_cnt));
  psq_timer #(.CAP(POST_CAP)) u_post (
    .clk(clk), .rst(rst), .clr(!perst_n_o), .tick(tick), .count(post_cnt));
  psq_timer #(.CAP(OFF_MS + 1)) u_off (
    .clk(clk), .rst(rst), .clr(st != PRE_OFF), .tick(tick), .count(off_cnt));

  assign pwr_done = pwr_cnt  > PW'(PWR_MS);
  assign clk_done = lead_cnt > {1'b0, clk_lead_ms_i};
  assign cfg_done = post_cnt > QW'(CFG_MS);
  assign off_done = off_cnt  > OW'(OFF_MS);
  assign det_late = post_cnt > (fast_link_i ? QW'(DET_FAST_MS) : QW'(DET_SLOW_MS));

  always_comb begin
    nxt = st;
    if (!pg_s) begin
      nxt = RESET_HOLD;
    end else begin
      case (st)
        RESET_HOLD: nxt = WAIT_POWER;
        WAIT_POWER: if (sleep_req_i) nxt = PRE_OFF;
                    else if (pwr_done) nxt = WAIT_CLK;
        WAIT_CLK:   if (sleep_req_i) nxt = PRE_OFF;
                    else if (clk_done) nxt = RELEASED;
        RELEASED:   if (sleep_req_i) nxt = PRE_OFF;
                    else if (cfg_done) nxt = CFG_WINDOW;
        CFG_WINDOW: if (sleep_req_i) nxt = PRE_OFF;
                    else if (det_seen) nxt = ACTIVE;
        ACTIVE:     if (sleep_req_i) nxt = PRE_OFF;
        PRE_OFF:    if (!sleep_req_i) nxt = RESET_HOLD;
        default:    nxt = RESET_HOLD;
      endcase
    end
  end

  assign nxt_rel = (nxt == RELEASED) || (nxt == CFG_WINDOW) || (nxt == ACTIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st               <= RESET_HOLD;
      perst_n_o        <= 1'b0;
      cfg_enable_o     <= 1'b0;
      power_off_ok_o   <= 1'b0;
      detect_timeout_o <= 1'b0;
      det_seen         <= 1'b0;
    end else begin
      st             <= nxt;
      perst_n_o      <= nxt_rel;
      cfg_enable_o   <= (nxt == CFG_WINDOW) || (nxt == ACTIVE);
      power_off_ok_o <= (nxt == PRE_OFF) && (st == PRE_OFF) && off_done;
      det_seen       <= nxt_rel && (det_seen || (perst_n_o && det_s));
      detect_timeout_o <= nxt_rel &&
        (detect_timeout_o || (perst_n_o && !det_seen && !det_s && det_late));
    end
  end

  // R1: release only after the power interval has run out
  p_pwr_delay_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(perst_n_o) |-> $past(pwr_done));
  // R2: release only after the clock lead interval has run out
  p_clk_lead_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(perst_n_o) |-> $past(clk_done));
  p_cfg_released_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_enable_o |-> perst_n_o);
  p_cfg_window_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_enable_o) |-> $past(cfg_done));
  p_sleep_assert_r4: assert property (@(posedge clk) disable iff (rst)
    (perst_n_o && sleep_req_i) |=> !perst_n_o);
  p_offok_in_reset_r4: assert property (@(posedge clk) disable iff (rst)
    power_off_ok_o |-> !perst_n_o);
  p_pg_loss_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(pg_s) |=> (!perst_n_o && !cfg_enable_o && !power_off_ok_o));
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (detect_timeout_o && perst_n_o && pg_s && !sleep_req_i) |=> detect_timeout_o);
  p_timeout_released_r7: assert property (@(posedge clk) disable iff (rst)
    detect_timeout_o |-> perst_n_o);
endmodule

// File: tb/perst_seq_tb_top.sv
module perst_seq_tb_top;
  localparam int CLK_HZ = 10_000;
  localparam int T = 10;

  typedef struct packed {
    logic [7:0] lead;
    logic [7:0] clkdly;
    logic       fast;
    logic [7:0] det;     // ms after release, 255 = never
    logic       exp_to;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'd10, 8'd0,   1'b0, 8'd5,   1'b0},
    '{8'd30, 8'd90,  1'b1, 8'd50,  1'b0},
    '{8'd5,  8'd150, 1'b0, 8'd50,  1'b1},
    '{8'd0,  8'd20,  1'b1, 8'd255, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pg = 1'b0, rclk = 1'b0, det = 1'b0, fast = 1'b0, sleep = 1'b0;
  logic [7:0] lead = 8'd0;
  logic perst_n, cfg_en, off_ok, det_to;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  perst_seq #(.CLK_HZ(CLK_HZ)) dut_i (
    .clk(clk), .rst(rst), .pwr_good_i(pg), .refclk_ok_i(rclk),
    .link_detect_i(det), .fast_link_i(fast), .clk_lead_ms_i(lead),
    .sleep_req_i(sleep), .perst_n_o(perst_n), .cfg_enable_o(cfg_en),
    .power_off_ok_o(off_ok), .detect_timeout_o(det_to));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Power up with given settings. Returns the cycles from pg rise to release.
  task automatic bring_up(input int ld, input int cdly, input bit fst, output int t);
    pg = 1'b0; rclk = 1'b0; det = 1'b0; sleep = 1'b0;
    repeat (5 * T) @(negedge clk);
    chk(perst_n == 1'b0 && cfg_en == 1'b0, "R5 held low while unpowered", perst_n, 0);
    lead = 8'(ld); fast = fst; pg = 1'b1; t = 0;
    while (!perst_n && t < 400 * T) begin
      if (t == cdly * T) rclk = 1'b1;
      @(negedge clk);
      t++;
    end
  endtask

  task automatic drop_power();
    pg = 1'b0;
    repeat (4) @(negedge clk);
    chk(perst_n == 1'b0 && cfg_en == 1'b0, "R5 unwarned loss asserts reset", perst_n, 0);
    chk(off_ok == 1'b0, "R5 no power-off permit", off_ok, 0);
    chk(det_to == 1'b0, "R7 timeout cleared by reset", det_to, 0);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t, r, need;
    repeat (3) @(negedge clk);
    chk(perst_n == 1'b0 && cfg_en == 1'b0 && off_ok == 1'b0 && det_to == 1'b0,
        "R8 reset state", {perst_n, cfg_en, off_ok, det_to}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(perst_n == 1'b0 && det_to == 1'b0, "R8 state after reset", perst_n, 0);

    foreach (VECS[i]) begin
      bring_up(VECS[i].lead, VECS[i].clkdly, VECS[i].fast, t);
      need = ((VECS[i].clkdly + VECS[i].lead > 100) ?
              VECS[i].clkdly + VECS[i].lead : 100) * T;
      chk(t >= 100 * T, "R1 power delay respected", t, 100 * T);
      chk(t >= need && t <= need + 2 * T + 10, "R2 release timing", t, need);
      r = 0;
      while (r < 112 * T) begin
        if (VECS[i].det != 8'd255 && r == VECS[i].det * T) det = 1'b1;
        if (cfg_en && r < 100 * T) chk(1'b0, "R3 early config enable", r, 100 * T);
        if (!cfg_en && r > 102 * T + 10) chk(1'b0, "R3 late config enable", r, 102 * T);
        @(negedge clk);
        r++;
      end
      chk(cfg_en == 1'b1, "R3 config enabled after window", cfg_en, 1);
      chk(det_to == VECS[i].exp_to, "R6 detect deadline", det_to, VECS[i].exp_to);
      if (VECS[i].exp_to) chk(det_to == 1'b1, "R7 sticky after late detect", det_to, 1);
      drop_power();
    end

    // R4: warned power-down
    bring_up(0, 0, 1'b0, t);
    det = 1'b1;
    repeat (101 * T + 20) @(negedge clk);
    chk(cfg_en == 1'b1, "R3 enable before sleep", cfg_en, 1);
    sleep = 1'b1;
    @(negedge clk);
    chk(perst_n == 1'b0 && cfg_en == 1'b0, "R4 sleep asserts reset next edge", perst_n, 0);
    chk(off_ok == 1'b0, "R4 no permit yet", off_ok, 0);
    r = 1;
    while (!off_ok && r < 10 * T) begin
      @(negedge clk);
      r++;
    end
    chk(r >= T && r <= 3 * T + 10, "R4 power-off permit delay", r, T);
    chk(perst_n == 1'b0, "R4 permit only in reset", perst_n, 0);
    pg = 1'b0;
    repeat (4) @(negedge clk);
    chk(off_ok == 1'b0 && perst_n == 1'b0, "R5 power gone clears permit", off_ok, 0);
    sleep = 1'b0;

    // R5: loss part-way through the power interval restarts it
    repeat (3 * T) @(negedge clk);
    rclk = 1'b1; pg = 1'b1; lead = 8'd0;
    repeat (60 * T) @(negedge clk);
    pg = 1'b0;
    repeat (T) @(negedge clk);
    pg = 1'b1; t = 0;
    while (!perst_n && t < 300 * T) begin
      @(negedge clk);
      t++;
    end
    chk(t >= 100 * T && t <= 102 * T + 10, "R5 full interval restarts", t, 100 * T);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule